// File: doc/BRIEF.md
# Sa6 Error Indication Counters

This block sits behind an E1 receive framer running CRC-4 multiframing. For each 8-frame CRC submultiframe it gathers the Sa6 spare bit from the four frames that carry no frame alignment word. It assembles those bits into a 4-bit code. Two event counters then decide whether that code reports an error. The far counter counts errors that the remote terminal reports back. The near counter counts errors found at the T reference point. The code 0011 reports both kinds at once, so it advances both counters.

The framer upstream supplies a strobe for each received frame, the frame's number within the 16-frame multiframe, and a flag that is high while multiframe alignment holds. Counting happens only while that flag is high. A code that was partly gathered when alignment dropped is thrown away. Software reads the counters by pulsing a read request. That copies both live counts into holding registers, which drive the outputs, and clears the live counts. An event that lands in the same cycle as the read is not lost.

Top module: `sa6_err_cnt`

## Requirements
- R1: Both counters are 16 bits wide. Each live count changes by at most +1 per cycle, except when it is cleared by a read. After reset both live counts and both holding outputs are zero.
- R2: The code for a submultiframe is built from the `sa6_bit` values of the strobed frames whose `frame_num` is odd (1,3,5,7 or 9,11,13,15). The bit from the earliest of those frames is the MSB. Bits sampled on even frames have no effect. The code is evaluated on the strobe of the last frame of the submultiframe, where `frame_num[2:0]` = 7.
- R3: The far counter increments when the code is 4'b0001 or 4'b0011, and for no other code.
- R4: The near counter increments when the code is 4'b0010 or 4'b0011, and for no other code. The code 0011 increments both counters in the same cycle.
- R5: Neither counter increments while `mf_sync` is low. This includes the case where `mf_sync` is low on the strobe of frame 7 or 15.
- R6: If `mf_sync` is low in any cycle, the code being gathered is discarded. Gathering resumes only at the next strobed frame with `frame_num[2:0]` = 0 while `mf_sync` is high.
- R7: A live count that has reached all ones stays there when further events arrive. It does not wrap.
- R8: A one-cycle `rd_req` copies both live counts, as they were before that edge, into the holding outputs on the next clock edge, and clears the live counts. If an event coincides with the read, the live count of the counter that event hits becomes 1.
- R9: The holding outputs change only on an edge where `rd_req` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_stb | input | 1 | One-cycle pulse per received frame |
| frame_num | input | 4 | Number of the strobed frame within the multiframe (0..15) |
| sa6_bit | input | 1 | Received Sa6 bit of the strobed frame |
| mf_sync | input | 1 | High while multiframe alignment holds |
| rd_req | input | 1 | Read pulse: latch both counts and clear them |
| far_cnt_o | output | 16 | Latched far-end error count (codes 0001, 0011) |
| near_cnt_o | output | 16 | Latched reference-point error count (codes 0010, 0011) |

## Verification
The live counts are visible only through a read, so any internal fault shows up in the value returned by the next `rd_req`. A bit gathered in the wrong order, a frame sampled on the wrong parity, or a collector left armed after a loss of alignment each change that value within one submultiframe. Mismatched codes and missing saturation show up the same way. A lost coincident event or a wrong clear shows up one read later, as a count off by one.

// File: rtl/sa6_pkg.sv
package sa6_pkg;

  // Saturating step of a counter with a clear that does not swallow the event.
  function automatic logic [31:0] sat_step(input logic [31:0] cur,
                                           input logic [31:0] top,
                                           input logic        bump,
                                           input logic        clr);
    logic [31:0] base;
    base = clr ? 32'd0 : cur;
    if (bump && base != top) return base + 32'd1;
    return base;
  endfunction

  // True when a gathered code equals either trigger pattern.
  function automatic logic code_hit(input logic [15:0] code,
                                    input logic [15:0] pat_a,
                                    input logic [15:0] pat_b);
    return (code == pat_a) || (code == pat_b);
  endfunction

endpackage

// File: rtl/sa6_code_collect.sv
module sa6_code_collect #(
  parameter int SMF_W  = 3,
  localparam int CODE_W = 2 ** (SMF_W - 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_stb,
  input  logic [SMF_W-1:0]  frame_pos,
  input  logic              sa6_bit,
  input  logic              mf_sync,
  output logic              code_done,
  output logic [CODE_W-1:0] code
);
  localparam logic [SMF_W-1:0] POS_LAST = '1;

  logic              armed;
  logic [CODE_W-1:0] shreg;
  logic              at_start, at_last, odd_frame;

  assign at_start  = (frame_pos == '0);
  assign at_last   = (frame_pos == POS_LAST);
  assign odd_frame = frame_pos[0];

  // Arms at a submultiframe start; any loss of alignment drops the partial code.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    armed <= 1'b0;
    else if (!mf_sync)             armed <= 1'b0;
    else if (frame_stb && at_start) armed <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      shreg <= '0;
    else if (frame_stb && odd_frame) shreg <= {shreg[CODE_W-2:0], sa6_bit};
  end

  assign code      = {shreg[CODE_W-2:0], sa6_bit};
  assign code_done = frame_stb && at_last && armed && mf_sync;

endmodule

// File: rtl/sa6_evt_counter.sv
module sa6_evt_counter
  import sa6_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  input  logic             rd_req,
  output logic [CNT_W-1:0] live,
  output logic [CNT_W-1:0] hold
);
  localparam logic [31:0] TOP = 32'((64'd1 << CNT_W) - 64'd1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live <= '0;
      hold <= '0;
    end else begin
      live <= CNT_W'(sat_step(32'(live), TOP, inc, rd_req));
      if (rd_req) hold <= live;
    end
  end

endmodule

// File: rtl/sa6_err_cnt.sv
module sa6_err_cnt
  import sa6_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int FN_W  = 4,
  parameter int SMF_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_stb,
  input  logic [FN_W-1:0]  frame_num,
  input  logic             sa6_bit,
  input  logic             mf_sync,
  input  logic             rd_req,
  output logic [CNT_W-1:0] far_cnt_o,
  output logic [CNT_W-1:0] near_cnt_o
);
  localparam int N_CNT  = 2;
  localparam int CODE_W = 2 ** (SMF_W - 1);
  // index 0: far-end reports, index 1: reference-point reports
  localparam logic [CODE_W-1:0] PAT_A [N_CNT] = '{CODE_W'(1), CODE_W'(2)};
  localparam logic [CODE_W-1:0] PAT_B = CODE_W'(3);

  logic              code_done;
  logic [CODE_W-1:0] code;
  logic [N_CNT-1:0]  evt;
  logic [CNT_W-1:0]  live_cnt [N_CNT];
  logic [CNT_W-1:0]  hold_cnt [N_CNT];
  logic              frame_hi_unused;

  // The multiframe half is irrelevant: both submultiframes are decoded alike.
  assign frame_hi_unused = ^frame_num[FN_W-1:SMF_W];

  sa6_code_collect #(.SMF_W(SMF_W)) u_collect (
    .clk       (clk),
    .rst_n     (rst_n),
    .frame_stb (frame_stb),
    .frame_pos (frame_num[SMF_W-1:0]),
    .sa6_bit   (sa6_bit),
    .mf_sync   (mf_sync),
    .code_done (code_done),
    .code      (code)
  );

  for (genvar g = 0; g < N_CNT; g++) begin : g_cnt
    assign evt[g] = code_done && code_hit(16'(code), 16'(PAT_A[g]), 16'(PAT_B));

    sa6_evt_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk    (clk),
      .rst_n  (rst_n),
      .inc    (evt[g]),
      .rd_req (rd_req),
      .live   (live_cnt[g]),
      .hold   (hold_cnt[g])
    );
  end

  assign far_cnt_o  = hold_cnt[0];
  assign near_cnt_o = hold_cnt[1];

endmodule

// File: rtl/sa6_err_cnt_chk.sv
module sa6_err_cnt_chk #(
  parameter int CNT_W  = 16,
  parameter int CODE_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mf_sync,
  input logic              rd_req,
  input logic              code_done,
  input logic [CODE_W-1:0] code,
  input logic [1:0]        evt,
  input logic [CNT_W-1:0]  far_live,
  input logic [CNT_W-1:0]  near_live,
  input logic [CNT_W-1:0]  far_hold,
  input logic [CNT_W-1:0]  near_hold
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
  localparam logic [CNT_W-1:0] MAX = '1;

  assert_single_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req |=> (far_live == $past(far_live) || far_live == $past(far_live) + ONE) &&
                (near_live == $past(near_live) || near_live == $past(near_live) + ONE));

  assert_far_codes_R3: assert property (@(posedge clk) disable iff (!rst_n)
    evt[0] |-> code_done && (code == CODE_W'(1) || code == CODE_W'(3)));

  assert_near_codes_R4: assert property (@(posedge clk) disable iff (!rst_n)
    evt[1] |-> code_done && (code == CODE_W'(2) || code == CODE_W'(3)));

  assert_both_on_0011_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (code_done && code == CODE_W'(3)) |-> evt == 2'b11);

  assert_sync_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !mf_sync |-> evt == 2'b00);

  assert_no_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (far_live == MAX && !rd_req) |=> far_live == MAX);

  assert_read_copy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> far_hold == $past(far_live) && near_hold == $past(near_live) &&
               far_live <= ONE && near_live <= ONE);

  assert_hold_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req |=> $stable(far_hold) && $stable(near_hold));

endmodule

bind sa6_err_cnt sa6_err_cnt_chk #(.CNT_W(CNT_W), .CODE_W(CODE_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .mf_sync   (mf_sync),
  .rd_req    (rd_req),
  .code_done (code_done),
  .code      (code),
  .evt       (evt),
  .far_live  (live_cnt[0]),
  .near_live (live_cnt[1]),
  .far_hold  (hold_cnt[0]),
  .near_hold (hold_cnt[1])
);

// File: tb/sa6_err_cnt_test.sv
module sa6_err_cnt_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frame_stb = 1'b0;
  logic [3:0]  frame_num = '0;
  logic        sa6_bit = 1'b0;
  logic        mf_sync = 1'b0;
  logic        rd_req = 1'b0;
  logic [15:0] far_cnt, near_cnt;
  logic [3:0]  far_sat, near_sat;
  int          checks = 0;
  int          errors = 0;
  int          smf_base = 0;

  always #2.5 clk = ~clk;  // 200 MHz

  sa6_err_cnt uut (
    .clk(clk), .rst_n(rst_n), .frame_stb(frame_stb), .frame_num(frame_num),
    .sa6_bit(sa6_bit), .mf_sync(mf_sync), .rd_req(rd_req),
    .far_cnt_o(far_cnt), .near_cnt_o(near_cnt));

  sa6_err_cnt #(.CNT_W(4)) uut_sat (
    .clk(clk), .rst_n(rst_n), .frame_stb(frame_stb), .frame_num(frame_num),
    .sa6_bit(sa6_bit), .mf_sync(mf_sync), .rd_req(rd_req),
    .far_cnt_o(far_sat), .near_cnt_o(near_sat));

  // {sync, code[3:0], far hit, near hit}
  localparam logic [6:0] VEC [0:13] = '{
    {1'b1, 4'b0000, 2'b00}, {1'b1, 4'b0001, 2'b10}, {1'b1, 4'b0010, 2'b01},
    {1'b1, 4'b0011, 2'b11}, {1'b1, 4'b1000, 2'b00}, {1'b1, 4'b0100, 2'b00},
    {1'b1, 4'b1011, 2'b00}, {1'b1, 4'b0111, 2'b00}, {1'b1, 4'b1111, 2'b00},
    {1'b1, 4'b1100, 2'b00}, {1'b0, 4'b0001, 2'b00}, {1'b0, 4'b0011, 2'b00},
    {1'b1, 4'b0011, 2'b11}, {1'b1, 4'b0010, 2'b01}};

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic frame(input int num, input logic b, input logic s, input logic rd);
    @(negedge clk);
    frame_stb = 1'b1; frame_num = num[3:0]; sa6_bit = b; mf_sync = s; rd_req = rd;
    @(negedge clk);
    frame_stb = 1'b0; rd_req = 1'b0;
  endtask

  // Even frames carry a 1 as noise; odd frames carry the code, MSB first.
  task automatic send_smf(input logic [3:0] code, input logic s, input logic rd_last);
    for (int i = 0; i < 8; i++)
      frame(smf_base + i, (i % 2 == 1) ? code[3 - i/2] : 1'b1, s, rd_last && i == 7);
    smf_base ^= 8;
  endtask

  task automatic do_read;
    @(negedge clk); rd_req = 1'b1;
    @(negedge clk); rd_req = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    check("R1 reset far", far_cnt, 16'h0);
    check("R1 reset near", near_cnt, 16'h0);
    rst_n = 1'b1;
    do_read;
    check("R1 empty read far", far_cnt, 16'h0);

    for (int v = 0; v < 14; v++) begin
      send_smf(VEC[v][5:2], VEC[v][6], 1'b0);
      do_read;
      check(VEC[v][6] ? "R3/R2 far code" : "R5 far unsynced", far_cnt, 16'(VEC[v][1]));
      check(VEC[v][6] ? "R4/R2 near code" : "R5 near unsynced", near_cnt, 16'(VEC[v][0]));
    end

    // R5: sync low exactly on the last frame of the submultiframe
    for (int i = 0; i < 8; i++)
      frame(smf_base + i, (i == 5 || i == 7) ? 1'b1 : 1'b0, i != 7, 1'b0);
    smf_base ^= 8;
    do_read;
    check("R5 sync lost at eval far", far_cnt, 16'h0);
    check("R5 sync lost at eval near", near_cnt, 16'h0);

    // R6: sync drops mid-submultiframe, returns before the code completes
    for (int i = 0; i < 4; i++) frame(smf_base + i, 1'b0, 1'b1, 1'b0);
    @(negedge clk); mf_sync = 1'b0;
    @(negedge clk); mf_sync = 1'b1;
    for (int i = 4; i < 8; i++) frame(smf_base + i, 1'b1, 1'b1, 1'b0);
    smf_base ^= 8;
    do_read;
    check("R6 partial discarded far", far_cnt, 16'h0);
    check("R6 partial discarded near", near_cnt, 16'h0);

    // R9 then R6 resume: event without read leaves outputs alone
    send_smf(4'b0011, 1'b1, 1'b0);
    check("R9 hold stable far", far_cnt, 16'h0);
    check("R9 hold stable near", near_cnt, 16'h0);
    do_read;
    check("R6 resumed far", far_cnt, 16'h1);
    check("R6 resumed near", near_cnt, 16'h1);

    // R8: read coincides with an event
    send_smf(4'b0001, 1'b1, 1'b0);
    send_smf(4'b0011, 1'b1, 1'b1);
    check("R8 coincident read far", far_cnt, 16'h1);
    check("R8 coincident read near", near_cnt, 16'h0);
    do_read;
    check("R8 event kept far", far_cnt, 16'h1);
    check("R8 event kept near", near_cnt, 16'h1);

    // R7 on the narrow instance, R1 width on the default one
    for (int k = 0; k < 20; k++) send_smf(4'b0011, 1'b1, 1'b0);
    do_read;
    check("R7 saturate far", 16'(far_sat), 16'hF);
    check("R7 saturate near", 16'(near_sat), 16'hF);
    check("R1 wide count far", far_cnt, 16'd20);
    check("R1 wide count near", near_cnt, 16'd20);
    do_read;
    check("R8 cleared after read", far_cnt, 16'h0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule